// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out the column address for every beat of a synchronous DRAM read or write burst. When a column command is accepted, it latches the starting column together with the burst settings held in the mode register image. These settings are the length code, the wrap order and the single-write option. From the next cycle on, it presents one column per clock with a beat-valid flag, and it raises a last-beat flag on the final beat of a fixed-length burst.

A new column command may arrive on any cycle. It replaces the burst in progress at once. A stop strobe ends the burst in progress. A full-page burst never ends by itself: it steps through all 512 columns, wraps from the top column back to zero, and keeps going until it is stopped or replaced. A reserved length code gives a single beat and sets an error flag.

The control is a small state machine with three states:
- `ST_IDLE`: no burst is running.
- `ST_BURST`: a burst of fixed length 1, 2, 4 or 8 is running.
- `ST_PAGE`: a full-page burst is running.

Its transitions are:
- **launch**: a start strobe in any state goes to `ST_BURST` or `ST_PAGE`, chosen by the decoded length.
- **finish**: in `ST_BURST`, the beat whose count equals length minus one returns to `ST_IDLE`.
- **halt**: a stop strobe without a start, in `ST_BURST` or `ST_PAGE`, goes to `ST_IDLE`.
- **advance**: any other cycle in `ST_BURST` or `ST_PAGE` stays in the same state and counts one more beat.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset, beat_valid, beat_last and len_err are all 0.
- R2: A start strobe sampled at a clock edge makes beat 0 appear from that edge. Beat 0 carries col_out equal to the start column in every mode. Beat n follows n cycles later.
- R3: When cfg_interleave=0, a burst of length BL (BL = 2^k) keeps the column bits above bit k-1 fixed. It adds the beat number to the low k bits, modulo BL. Example: start 0x0D with BL=4 gives 0x0D, 0x0E, 0x0F, 0x0C.
- R4: When cfg_interleave=1, beat n of a burst of length 2^k replaces the low k bits of the start column with those bits XOR n. Example: start 0x0D with BL=8 gives 0x0D, 0x0C, 0x0F, 0x0E, 0x09, 0x08, 0x0B, 0x0A.
- R5: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 beats. beat_last is 1 only on the final beat, and beat_valid drops on the cycle after it.
- R6: Code 3'b111 with cfg_interleave=0 gives a full-page burst. The column steps by one modulo 512 (0x1FF is followed by 0x000), beat_last stays 0, and the burst runs until it is stopped or replaced.
- R7: A cmd_stop sampled without cmd_start makes beat_valid 0 from that edge on.
- R8: A cmd_start sampled during a burst restarts the burst with the new column and settings from that edge. cmd_start takes priority over a simultaneous cmd_stop.
- R9: When cfg_single_wr=1, a write start (cmd_is_write=1) gives exactly one beat whatever the length code. Reads keep the programmed length.
- R10: Codes 3'b100, 3'b101, 3'b110, and 3'b111 with cfg_interleave=1, are reserved. They give one beat and set len_err. len_err changes only at a start and keeps its value until the next start.
- R11: Configuration inputs are sampled only at a start. Changing them during a burst has no effect on its columns or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_code | input | 3 | Burst length code from the mode image |
| cfg_interleave | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| cfg_single_wr | input | 1 | 1 makes write bursts a single beat |
| cmd_start | input | 1 | Column command accepted this cycle |
| cmd_is_write | input | 1 | The column command is a write |
| cmd_col | input | 9 | Starting column of the command |
| cmd_stop | input | 1 | Burst-stop command this cycle |
| col_out | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| len_err | output | 1 | Last start used a reserved length code |

## Verification
A wrong state register shows up as extra beats, missing beats or a beat_last in the wrong place. The scoreboard sees this on the first beat that differs. A wrong beat count, latched base or wrap mask gives a wrong col_out on some beat of the same burst, no later than beat 7 for fixed lengths. For full pages it shows at the 0x1FF to 0x000 wrap. A wrong state after a stop or restart shows on the very next cycle, as a valid beat that should be absent or a column that does not match the new start.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } cg_state_e;

    localparam int LEN_CODE_W = 3;
    localparam int LG_W       = 2;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
    import colgen_pkg::*;
(
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  interleave,
    input  logic                  single_wr,
    input  logic                  is_write,
    output logic [LG_W-1:0]       lg,
    output logic                  full_page,
    output logic                  reserved
);

    always_comb begin
        lg        = '0;
        full_page = 1'b0;
        reserved  = 1'b0;
        unique case (len_code)
            3'b000: lg = 2'd0;
            3'b001: lg = 2'd1;
            3'b010: lg = 2'd2;
            3'b011: lg = 2'd3;
            3'b111: begin
                if (interleave) reserved  = 1'b1;
                else            full_page = 1'b1;
            end
            default: reserved = 1'b1;
        endcase
        if (is_write && single_wr) begin
            lg        = '0;
            full_page = 1'b0;
        end
    end

endmodule

// File: rtl/colgen_col_calc.sv
module colgen_col_calc
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [LG_W-1:0]  lg,
    input  logic             full_page,
    input  logic             interleave,
    output logic [COL_W-1:0] wrap_mask,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_part;

    always_comb begin
        for (int i = 0; i < COL_W; i++) begin
            wrap_mask[i] = full_page | (i < int'(lg));
        end
    end

    always_comb begin
        if (interleave && !full_page) low_part = base ^ beat;
        else                          low_part = base + beat;
        col = (base & ~wrap_mask) | (low_part & wrap_mask);
    end

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_len_code,
    input  logic             cfg_interleave,
    input  logic             cfg_single_wr,
    input  logic             cmd_start,
    input  logic             cmd_is_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    output logic [COL_W-1:0] col_out,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             len_err
);

    cg_state_e        state_q, state_d;
    logic [COL_W-1:0] base_q, cnt_q, cnt_d;
    logic [LG_W-1:0]  lg_q, lg_new;
    logic             ilv_q, err_q;
    logic             full_new, rsv_new;
    logic [COL_W-1:0] mask_cur;
    logic [COL_W-1:0] col_cur;

    colgen_len_decode u_dec (
        .len_code   (cfg_len_code),
        .interleave (cfg_interleave),
        .single_wr  (cfg_single_wr),
        .is_write   (cmd_is_write),
        .lg         (lg_new),
        .full_page  (full_new),
        .reserved   (rsv_new)
    );

    colgen_col_calc #(.COL_W(COL_W)) u_calc (
        .base       (base_q),
        .beat       (cnt_q),
        .lg         (lg_q),
        .full_page  (state_q == ST_PAGE),
        .interleave (ilv_q),
        .wrap_mask  (mask_cur),
        .col        (col_cur)
    );

    // next-state and beat counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = cnt_q;
            end
            ST_BURST: begin
                if (cmd_stop || cnt_q == mask_cur) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (cmd_stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (cmd_start) begin
            state_d = full_new ? ST_PAGE : ST_BURST;
            cnt_d   = '0;
        end
    end

    // state register and latched command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            lg_q    <= '0;
            ilv_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (cmd_start) begin
                base_q <= cmd_col;
                lg_q   <= lg_new;
                ilv_q  <= cfg_interleave;
                err_q  <= rsv_new;
            end
        end
    end

    // outputs
    always_comb begin
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        col_out    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BURST: begin
                beat_valid = 1'b1;
                beat_last  = (cnt_q == mask_cur);
                col_out    = col_cur;
            end
            ST_PAGE: begin
                beat_valid = 1'b1;
                col_out    = col_cur;
            end
            default: ;
        endcase
        len_err = err_q;
    end

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_single_wr,
    input logic             cmd_start,
    input logic             cmd_is_write,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_stop,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             beat_last,
    input logic             len_err
);

    // R5: a final beat is always a valid beat
    p_last_is_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R5: nothing follows the final beat unless a new start arrives
    p_quiet_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !cmd_start) |=> !beat_valid);

    // R7: stop without start ends the burst
    p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start) |=> !beat_valid);

    // R2 / R8: beat 0 carries the start column
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (beat_valid && col_out == $past(cmd_col)));

    // R9: single-write mode writes are one beat
    p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_is_write && cfg_single_wr) |=> beat_last);

    // R10: the error flag moves only at a start
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_start |=> $stable(len_err));

endmodule

bind sdr_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_single_wr (cfg_single_wr),
    .cmd_start     (cmd_start),
    .cmd_is_write  (cmd_is_write),
    .cmd_col       (cmd_col),
    .cmd_stop      (cmd_stop),
    .col_out       (col_out),
    .beat_valid    (beat_valid),
    .beat_last     (beat_last),
    .len_err       (len_err)
);

// File: tb/sim_sdr_burst_colgen.sv
module sim_sdr_burst_colgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_len_code = '0;
    logic       cfg_interleave = 1'b0;
    logic       cfg_single_wr = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_is_write = 1'b0;
    logic [8:0] cmd_col = '0;
    logic       cmd_stop = 1'b0;
    logic [8:0] col_out;
    logic       beat_valid, beat_last, len_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [8:0] q_col[$];
    logic       q_last[$];
    string      q_tag[$];

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    sdr_burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_len_code(cfg_len_code),
        .cfg_interleave(cfg_interleave), .cfg_single_wr(cfg_single_wr),
        .cmd_start(cmd_start), .cmd_is_write(cmd_is_write), .cmd_col(cmd_col),
        .cmd_stop(cmd_stop), .col_out(col_out), .beat_valid(beat_valid),
        .beat_last(beat_last), .len_err(len_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected beats from the wrap rules of the requirements
    task automatic push_exp(input int base, input int bl, input bit ilv, input bit full,
                            input int nbeats, input string tag);
        for (int n = 0; n < nbeats; n++) begin
            int c;
            if (full)      c = (base + n) % 512;
            else if (ilv)  c = base - (base % bl) + ((base % bl) ^ n);
            else           c = base - (base % bl) + ((base % bl + n) % bl);
            q_col.push_back(9'(c));
            q_last.push_back(!full && n == bl - 1);
            q_tag.push_back(tag);
        end
    endtask

    // caller is at a negedge; returns at the negedge where beat 0 is visible
    task automatic issue(input int col, input int code, input bit ilv, input bit wr,
                         input bit sw, input bit stp);
        cmd_col = 9'(col); cfg_len_code = 3'(code); cfg_interleave = ilv;
        cmd_is_write = wr; cfg_single_wr = sw; cmd_start = 1'b1; cmd_stop = stp;
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        check(beat_valid == 1'b0, {tag, " idle"}, beat_valid, 0);
        check(q_col.size() == 0, {tag, " beats missing"}, q_col.size(), 0);
        q_col.delete(); q_last.delete(); q_tag.delete();
    endtask

    task automatic full_burst(input int col, input int code, input bit ilv, input bit wr,
                              input bit sw, input int bl, input string tag);
        push_exp(col, bl, ilv, 1'b0, bl, tag);
        issue(col, code, ilv, wr, sw, 1'b0);
        repeat (bl) @(negedge clk);
        check_idle(tag);
        @(negedge clk);
    endtask

    // monitor: compares each presented beat against the scoreboard
    always @(negedge clk) begin
        if (rst_n && beat_valid) begin
            if (q_col.size() == 0) begin
                check(1'b0, "extra beat", col_out, 0);
            end else begin
                logic [8:0] ec;
                logic       el;
                string      et;
                ec = q_col.pop_front(); el = q_last.pop_front(); et = q_tag.pop_front();
                check(col_out == ec, {et, " col"}, col_out, ec);
                check(beat_last == el, {et, " last"}, beat_last, el);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(beat_valid == 0, "R1 valid", beat_valid, 0);
        check(beat_last == 0, "R1 last", beat_last, 0);
        check(len_err == 0, "R1 err", len_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(beat_valid == 0, "R1 valid after release", beat_valid, 0);

        // R2 R3 R5 sequential lengths
        full_burst('h0D, 3'b010, 0, 0, 0, 4, "R3 seq BL4");
        full_burst('h123, 3'b000, 0, 0, 0, 1, "R5 BL1");
        full_burst('h0B, 3'b001, 0, 0, 0, 2, "R5 BL2 seq");
        full_burst('h1FE, 3'b011, 0, 1, 0, 8, "R5 BL8 seq write");
        // R4 interleaved
        full_burst('h0D, 3'b011, 1, 0, 0, 8, "R4 ilv BL8");
        full_burst('h0B, 3'b001, 1, 0, 0, 2, "R4 ilv BL2");
        full_burst('h16, 3'b010, 1, 0, 0, 4, "R4 ilv BL4");

        // R6 full page wrap, then R7 stop
        push_exp('h1FD, 512, 0, 1, 7, "R6 page");
        issue('h1FD, 3'b111, 0, 0, 0, 0);
        repeat (6) @(negedge clk);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        check_idle("R7 page stop");
        @(negedge clk);

        // R7 stop a fixed burst after 3 beats
        push_exp('h40, 8, 0, 0, 3, "R7 stop");
        issue('h40, 3'b011, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        check_idle("R7 fixed stop");
        @(negedge clk);

        // R8 restart with simultaneous stop
        push_exp('h10, 8, 0, 0, 2, "R8 first");
        issue('h10, 3'b011, 0, 0, 0, 0);
        @(negedge clk);
        push_exp('h22, 4, 1, 0, 4, "R8 second");
        issue('h22, 3'b010, 1, 0, 0, 1);
        repeat (4) @(negedge clk);
        check_idle("R8 restart");
        @(negedge clk);

        // R9 single write vs read
        full_burst('h33, 3'b011, 0, 1, 1, 1, "R9 single write");
        full_burst('h33, 3'b011, 0, 0, 1, 8, "R9 read keeps length");
        full_burst('h7F, 3'b111, 0, 1, 1, 1, "R9 single write page code");

        // R10 reserved codes
        push_exp('h55, 1, 0, 0, 1, "R10 code100");
        issue('h55, 3'b100, 0, 0, 0, 0);
        check(len_err == 1, "R10 err set", len_err, 1);
        @(negedge clk);
        check_idle("R10 code100");
        repeat (3) @(negedge clk);
        check(len_err == 1, "R10 err held", len_err, 1);
        push_exp('h56, 1, 0, 0, 1, "R10 ilv page");
        issue('h56, 3'b111, 1, 0, 0, 0);
        check(len_err == 1, "R10 ilv page err", len_err, 1);
        @(negedge clk);
        check_idle("R10 ilv page");
        full_burst('h57, 3'b001, 0, 0, 0, 2, "R10 clear");
        check(len_err == 0, "R10 err cleared", len_err, 0);

        // R11 config changes mid-burst are ignored
        push_exp('h05, 4, 0, 0, 4, "R11 cfg hold");
        issue('h05, 3'b010, 0, 0, 0, 0);
        cfg_len_code = 3'b000; cfg_interleave = 1'b1; cmd_col = 9'h1AA;
        repeat (4) @(negedge clk);
        check_idle("R11 cfg hold");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule